// File: doc/BRIEF.md
# Multi-Engine Run Control Register

This block is one 32-bit control word that a host writes to run and halt four small execution engines. The low nibble holds a persistent run mask, one bit per engine. A 1 lets that engine fetch its own program. A 0 halts it, but a halted engine still executes instructions that the host injects through the engine's separate injection port. A single write sets the whole mask, so any group of engines starts or stops in the same cycle.

Two further nibbles are write-one command fields. They are not storage. Bits 7:4 send a state-clear pulse to the matching engines. On that pulse an engine zeroes its input and output shift counters, its input shift register, its delay counter and any wait-on-interrupt condition. It also drops a stalled injected or self-executed instruction and releases a held sticky pin write. The pulse leaves the program counter, the output shift register and the X and Y scratch registers as they are. Bits 11:8 send a restart pulse to the matching engines' clock dividers. Setting several of these bits in one write restarts those dividers in the same cycle, so they stay in lockstep.

Each pulse lasts one clock cycle per write and reads back as 0. The engines, their decode and the dividers sit outside this block and only consume its outputs.

Top module: `eng_run_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `run_en`, `state_clr`, `div_restart` and `rd_data` are all 0 after that edge.
- R2: A write (`wr_en`=1) loads `wr_data[3:0]` into `run_en` (bit i drives engine i), visible from the next clock edge. Any combination of bits is accepted, so engines start and stop together.
- R3: Without a write, `run_en` keeps its value on every clock.
- R4: A write with `wr_data[4+i]`=1 raises `state_clr[i]` for exactly the one cycle after that write's edge. `state_clr` is 0 in every cycle that does not follow a write.
- R5: A write with `wr_data[8+i]`=1 raises `div_restart[i]` for exactly the one cycle after that write's edge. All bits set in one write pulse in the same cycle.
- R6: `rd_data[11:4]` always reads 0, whatever was written to the strobe fields.
- R7: `wr_data[31:12]` has no effect on any output, and `rd_data[31:12]` always reads 0. `rd_data[3:0]` equals `run_en`.
- R8: A single write that sets clear bits and changes the run mask makes the `state_clr` pulse and the new `run_en` value appear in the same cycle.
- R9: Writes on back-to-back cycles with the same strobe bit set give one pulse per write, so the strobe stays high for one cycle per write.
- R10: A state-clear pulse reaches an engine whether or not it is running; the pulse does not depend on `run_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data: run mask in [3:0], zeros elsewhere |
| run_en | output | 4 | Per-engine run enable levels |
| state_clr | output | 4 | Per-engine one-cycle state-clear pulses |
| div_restart | output | 4 | Per-engine one-cycle divider-restart pulses |

## Verification
The run mask is driven with alternating, complementary, full and empty patterns. These show that each bit is loaded on its own and is held across idle cycles. Strobe writes set every bit at once, single bits, and a mixture of clear bits with an enable change, which separates the three fields and shows they share one cycle. Back-to-back strobe writes and a write with only the reserved bits set show that pulses follow writes one for one and that reserved data reaches no output. Clears issued with every engine halted show the pulse is independent of the mask, and a reset in mid-run returns everything to zero.

// File: rtl/eng_run_ctrl_pkg.sv
// Shared constants for the engine run control register.
// Assumes the three per-engine fields are packed contiguously from bit 0.
package eng_run_ctrl_pkg;
    localparam int unsigned ENG_COUNT = 4;
    localparam int unsigned REG_W     = 32;
    // Field order: run mask, then state-clear, then divider-restart.
    localparam int unsigned FIELD_COUNT = 3;
endpackage

// File: rtl/erc_wr_decode.sv
// Splits a host write into a run-mask load and the two strobe request vectors.
// Assumes fields are N_ENG wide and packed from bit 0; upper bits are reserved.
module erc_wr_decode #(
    parameter int unsigned N_ENG  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mask_ld,
    output logic [N_ENG-1:0]  mask_val,
    output logic [N_ENG-1:0]  clr_req,
    output logic [N_ENG-1:0]  rst_req
);
    localparam int unsigned CLR_LSB = N_ENG;
    localparam int unsigned RST_LSB = 2 * N_ENG;
    localparam int unsigned USED_W  = 3 * N_ENG;

    // Reserved write bits are consumed here only so they feed nothing.
    logic unused_reserved;
    assign unused_reserved = ^wr_data[DATA_W-1:USED_W];

    // Field extraction; strobe requests exist only during a write.
    always_comb begin
        mask_ld  = wr_en;
        mask_val = wr_data[N_ENG-1:0];
        clr_req  = wr_en ? wr_data[CLR_LSB +: N_ENG] : '0;
        rst_req  = wr_en ? wr_data[RST_LSB +: N_ENG] : '0;
    end
endmodule

// File: rtl/erc_mask_reg.sv
// Persistent per-engine run mask, overwritten as a whole on each load.
// Assumes a synchronous active-low reset to all-halted.
module erc_mask_reg #(
    parameter int unsigned N_ENG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [N_ENG-1:0] val,
    output logic [N_ENG-1:0] mask
);
    // Load the mask on a write, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  mask <= '0;
        else if (ld) mask <= val;
    end

    // R3: the mask holds when no load arrives.
    a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(mask));
    // R2: a load shows up on the next edge.
    a_r2_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (mask == $past(val)));
endmodule

// File: rtl/erc_pulse_bank.sv
// Bank of self-clearing one-cycle pulses, one per engine.
// Assumes requests are already qualified by a write; each request yields one pulse.
module erc_pulse_bank #(
    parameter int unsigned N_ENG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ENG-1:0] req,
    output logic [N_ENG-1:0] pulse
);
    for (genvar g = 0; g < N_ENG; g++) begin : g_bit
        // Register the request for exactly one cycle; it clears unless re-requested.
        always_ff @(posedge clk) begin
            if (!rst_n) pulse[g] <= 1'b0;
            else        pulse[g] <= req[g];
        end

        // R4/R5: a request produces a pulse on the next cycle.
        a_r4_req_pulses: assert property (@(posedge clk) disable iff (!rst_n)
            req[g] |=> pulse[g]);
        // R9: without a fresh request the pulse drops after one cycle.
        a_r9_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
            !req[g] |=> !pulse[g]);
    end
endmodule

// File: rtl/eng_run_ctrl.sv
// Run control register for a group of execution engines: a persistent run
// mask plus write-one state-clear and divider-restart strobes.
// Assumes a single-register port (no address) and a synchronous active-low reset.
module eng_run_ctrl
    import eng_run_ctrl_pkg::*;
#(
    parameter int unsigned N_ENG  = ENG_COUNT,
    parameter int unsigned DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_ENG-1:0]  run_en,
    output logic [N_ENG-1:0]  state_clr,
    output logic [N_ENG-1:0]  div_restart
);
    localparam int unsigned USED_W = FIELD_COUNT * N_ENG;

    logic             mask_ld;
    logic [N_ENG-1:0] mask_val;
    logic [N_ENG-1:0] clr_req;
    logic [N_ENG-1:0] rst_req;

    erc_wr_decode #(.N_ENG(N_ENG), .DATA_W(DATA_W)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mask_ld (mask_ld),
        .mask_val(mask_val),
        .clr_req (clr_req),
        .rst_req (rst_req)
    );

    erc_mask_reg #(.N_ENG(N_ENG)) u_mask (
        .clk  (clk),
        .rst_n(rst_n),
        .ld   (mask_ld),
        .val  (mask_val),
        .mask (run_en)
    );

    erc_pulse_bank #(.N_ENG(N_ENG)) u_clr (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (clr_req),
        .pulse(state_clr)
    );

    erc_pulse_bank #(.N_ENG(N_ENG)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (rst_req),
        .pulse(div_restart)
    );

    // Readback: the run mask only; strobe and reserved fields read as zero.
    always_comb begin
        rd_data = '0;
        rd_data[N_ENG-1:0] = run_en;
    end

    // R1: reset empties every output.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (run_en == '0 && state_clr == '0 && div_restart == '0));
    // R6/R7: nothing above the run mask reads back.
    a_r6_readback_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:N_ENG] == '0);
    // R4: no strobe without a preceding write.
    a_r4_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (state_clr == '0 && div_restart == '0));
    // R8: a clear and a mask change in one write land together.
    a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2*N_ENG-1:N_ENG] != '0) |=>
            (state_clr != '0 && run_en == $past(wr_data[N_ENG-1:0])));
    // R7: reserved write bits alone change no strobe.
    a_r7_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[USED_W-1:N_ENG] == '0) |=>
            (state_clr == '0 && div_restart == '0));
endmodule

// File: tb/eng_run_ctrl_test.sv
`timescale 1ns/1ps
module eng_run_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  run_en, state_clr, div_restart;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string tag = "R1";

    // Behavioural reference state.
    logic [3:0] m_en = '0, m_clr = '0, m_div = '0;

    always #10 clk = ~clk;  // 50 MHz

    eng_run_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .run_en(run_en), .state_clr(state_clr),
        .div_restart(div_restart)
    );

    // Reference model update from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= '0; m_clr <= '0; m_div <= '0;
        end else if (wr_en) begin
            m_en  <= wr_data[3:0];
            m_clr <= wr_data[7:4];
            m_div <= wr_data[11:8];
        end else begin
            m_clr <= '0; m_div <= '0;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (run_en !== m_en || state_clr !== m_clr || div_restart !== m_div) begin
                fails++;
                $display("FAIL %s: en/clr/div actual %h/%h/%h expected %h/%h/%h",
                         tag, run_en, state_clr, div_restart, m_en, m_clr, m_div);
            end
            checks++;
            if (rd_data !== {28'h0, m_en}) begin
                fails++;
                $display("FAIL R6,R7 readback: actual %h expected %h", rd_data, {28'h0, m_en});
            end
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tag = "R1"; idle(3);
        @(negedge clk); #1; rst_n = 1'b1;
        tag = "R2"; wr(32'h5); wr(32'hA); wr(32'hF); wr(32'h0); wr(32'h9);
        tag = "R3"; idle(5);
        tag = "R4"; wr(32'h0F9); wr(32'h029); idle(2);
        tag = "R5"; wr(32'hF09); wr(32'h509); idle(2);
        tag = "R8"; wr(32'h0A3); idle(2);
        tag = "R9";
        @(negedge clk); #1; wr_en = 1'b1; wr_data = 32'h113;
        @(negedge clk); #1; wr_data = 32'h113;
        @(negedge clk); #1; wr_data = 32'h213;
        @(negedge clk); #1; wr_en = 1'b0; wr_data = '0;
        idle(2);
        tag = "R7"; wr(32'hFFFF_F006); wr(32'hABCD_E000); idle(2);
        tag = "R10"; wr(32'h0); wr(32'h0F0); wr(32'h050); idle(2);
        tag = "R6"; wr(32'hFFF); idle(2);
        tag = "R1"; @(negedge clk); #1; rst_n = 1'b0; idle(2);
        @(negedge clk); #1; rst_n = 1'b1; idle(2);
        finish_run();
    end
endmodule